// File: doc/BRIEF.md
# Shared Packed Substitution Table Unit

This unit carries out the substitution step of a 64-bit Feistel block cipher of the DES family on a 48-bit word that has already been expanded and mixed with the round key. Its eight 6-in/4-out substitution boxes are not built as eight separate lookup tables. They sit together in one 256-location, 8-bit-wide table, two 4-bit entries per byte. The 48-bit word is latched on a start pulse. The unit then walks the eight 6-bit groups, one per clock, through the single registered read port. For each group it computes the byte address, picks the correct half of the returned byte and shifts the 4-bit result into a 32-bit output word. A one-cycle done pulse marks the word as complete.

The same read port also serves byte-wide lookups for a 128-bit block cipher datapath that shares the table. In that mode a byte on the lookup input is used directly as the table address. The full stored byte comes back one clock later. The inverse-byte table of that cipher, the permutation that follows substitution, the expansion, the key schedules and the round logic all live outside this unit.

Top module: `sbx_shared_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, busy_o and done_o are 0, des_out_o is 0 and sub_byte_o is 0.
- R2: The table byte at address a holds two entries of substitution box number a[7:5] (0 = first box): entry 2*a[4:0] in bits [7:4] and entry 2*a[4:0]+1 in bits [3:0]. Address 0 therefore holds 0xE4.
- R3: When the unit is idle and mode_i is 1 (byte-lookup mode), sub_byte_o on the following cycle equals the table byte at the address given by aes_byte_i.
- R4: When the unit is idle and mode_i is 0 (Feistel mode), the table is not read and sub_byte_o keeps its value whatever aes_byte_i does.
- R5: A start_i pulse with mode_i = 0 while idle latches des_in_i, and busy_o is 1 from the next cycle.
- R6: Box k (k = 0..7) takes input bits [47-6k : 42-6k] as a group b5..b0. Its entry index is row*16 + column, with row {b5,b0} and column b4..b1. The entry is placed in des_out_o bits [31-4k : 28-4k].
- R7: done_o goes to 1 exactly nine clock edges after the edge that accepted the start. It stays high for one cycle, busy_o falls on the same edge, and des_out_o is complete when done_o is 1.
- R8: A start_i pulse that arrives while busy_o is 1 is ignored. It changes neither the result nor the timing of done_o.
- R9: A start_i pulse with mode_i = 1 is ignored, and busy_o stays 0.
- R10: While the unit is idle and done_o is 0, des_out_o holds the last completed result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = Feistel substitution, 1 = byte lookup |
| start_i | input | 1 | Begin an eight-group substitution (Feistel mode, idle only) |
| des_in_i | input | 48 | Expanded, key-mixed word, first box in the top six bits |
| aes_byte_i | input | 8 | Table address for byte-lookup mode |
| busy_o | output | 1 | Substitution sequence in progress |
| done_o | output | 1 | One-cycle pulse: des_out_o is complete |
| des_out_o | output | 32 | Substituted word, first box in the top nibble |
| sub_byte_o | output | 8 | Registered table byte for byte-lookup mode |

## Verification
A byte lookup is due one edge after the address is presented, so the bench drives on the falling edge and reads sub_byte_o at the next falling edge. A substitution result is due nine edges after the accepting edge. For every operation the bench samples done_o at each falling edge in between and expects it low at edges one to eight and high at edge nine, then low again at edge ten. Only at edge nine does it compare every nibble of des_out_o with the value computed from the reference boxes.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

   localparam int NBOX    = 8;
   localparam int GRP_W   = 6;
   localparam int NIB_W   = 4;
   localparam int TBL_AW  = 8;
   localparam int TBL_DW  = 8;
   localparam int BOX_ENT = 1 << GRP_W;
   localparam int BOX_BITS = BOX_ENT * NIB_W;

   typedef enum logic {
      MODE_DES = 1'b0,
      MODE_AES = 1'b1
   } sbx_mode_e;

   // One row of 64 nibbles per box, entry 0 in the top nibble.
   localparam logic [BOX_BITS-1:0] BOX_ROM [NBOX] = '{
      256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
      256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
      256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
      256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
      256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
      256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
      256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
      256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
   };

   function automatic logic [NIB_W-1:0] box_entry(input logic [2:0] box,
                                                  input logic [5:0] idx);
      int hi;
      hi = BOX_BITS - 1 - NIB_W * int'(idx);
      return BOX_ROM[box][hi -: NIB_W];
   endfunction

   // Two consecutive entries of one box share a byte, earlier one on top.
   function automatic logic [7:0] packed_byte(input logic [7:0] addr);
      logic [5:0] even_idx;
      even_idx = {addr[4:0], 1'b0};
      return {box_entry(addr[7:5], even_idx), box_entry(addr[7:5], even_idx | 6'd1)};
   endfunction

endpackage

// File: rtl/sbx_rom.sv
module sbx_rom #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] q
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   for (genvar a = 0; a < DEPTH; a++) begin : g_fill
      assign mem[a] = DW'(sbx_pkg::packed_byte(8'(a)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (rd_en) begin
         q <= mem[addr];
      end
   end

endmodule

// File: rtl/sbx_addr.sv
module sbx_addr #(
   parameter int NBOX  = 8,
   parameter int GRP_W = 6,
   parameter int AW    = 8
) (
   input  logic [NBOX*GRP_W-1:0]     word_i,
   input  logic [$clog2(NBOX)-1:0]   box_i,
   output logic [AW-1:0]             addr_o,
   output logic                      lo_sel_o
);

   localparam int BOX_W = $clog2(NBOX);

   logic [GRP_W-1:0] grp [NBOX];
   logic [GRP_W-1:0] sel_grp;
   logic [GRP_W-1:0] idx;

   // Box 0 owns the most significant group.
   for (genvar g = 0; g < NBOX; g++) begin : g_split
      assign grp[g] = word_i[(NBOX-g)*GRP_W-1 -: GRP_W];
   end

   always_comb begin
      sel_grp  = grp[box_i];
      // row = outer bits, column = inner bits
      idx      = {sel_grp[GRP_W-1], sel_grp[0], sel_grp[GRP_W-2:1]};
      addr_o   = AW'({box_i, idx[GRP_W-1:1]});
      lo_sel_o = idx[0];
   end

   if (BOX_W + GRP_W - 1 != AW) begin : g_bad_aw
      $error("sbx_addr: address width does not match box and index widths");
   end

endmodule

// File: rtl/sbx_seq.sv
module sbx_seq #(
   parameter int NBOX  = 8,
   parameter int GRP_W = 6,
   parameter int NIB_W = 4,
   parameter int DW    = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      go_i,
   input  logic [NBOX*GRP_W-1:0]     word_i,
   input  logic [DW-1:0]             rom_q_i,
   input  logic                      lo_sel_i,
   output logic                      busy_o,
   output logic                      rd_en_o,
   output logic [$clog2(NBOX)-1:0]   box_o,
   output logic [NBOX*GRP_W-1:0]     word_o,
   output logic                      done_o,
   output logic [NBOX*NIB_W-1:0]     result_o
);

   localparam int BOX_W = $clog2(NBOX);
   localparam int STEP_W = BOX_W + 1;
   localparam int OUT_W = NBOX * NIB_W;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NBOX);

   logic                  busy_q;
   logic [STEP_W-1:0]     step_q;
   logic [NBOX*GRP_W-1:0] word_q;
   logic                  vld_q;
   logic                  lo_q;
   logic                  done_q;
   logic [OUT_W-1:0]      res_q;
   logic                  issue;
   logic [NIB_W-1:0]      nib;

   assign issue = busy_q && (step_q != LAST_STEP);
   assign nib   = lo_q ? rom_q_i[NIB_W-1:0] : rom_q_i[DW-1 -: NIB_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
         lo_q   <= 1'b0;
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         vld_q  <= issue;
         lo_q   <= lo_sel_i;
         if (vld_q) begin
            res_q <= {res_q[OUT_W-NIB_W-1:0], nib};
         end
         if (!busy_q) begin
            if (go_i) begin
               busy_q <= 1'b1;
               step_q <= '0;
               word_q <= word_i;
            end
         end else if (step_q == LAST_STEP) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            step_q <= step_q + STEP_W'(1);
         end
      end
   end

   assign busy_o   = busy_q;
   assign rd_en_o  = issue;
   assign box_o    = step_q[BOX_W-1:0];
   assign word_o   = word_q;
   assign done_o   = done_q;
   assign result_o = res_q;

endmodule

// File: rtl/sbx_shared_unit.sv
module sbx_shared_unit #(
   parameter int NBOX   = sbx_pkg::NBOX,
   parameter int GRP_W  = sbx_pkg::GRP_W,
   parameter int NIB_W  = sbx_pkg::NIB_W,
   parameter int TBL_AW = sbx_pkg::TBL_AW,
   parameter int TBL_DW = sbx_pkg::TBL_DW
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    mode_i,
   input  logic                    start_i,
   input  logic [NBOX*GRP_W-1:0]   des_in_i,
   input  logic [TBL_AW-1:0]       aes_byte_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic [NBOX*NIB_W-1:0]   des_out_o,
   output logic [TBL_DW-1:0]       sub_byte_o
);

   import sbx_pkg::*;

   localparam int BOX_W = $clog2(NBOX);
   localparam int IN_W  = NBOX * GRP_W;

   if (NBOX != sbx_pkg::NBOX || GRP_W != sbx_pkg::GRP_W || NIB_W != sbx_pkg::NIB_W) begin : g_bad_box
      $error("sbx_shared_unit: box geometry must match the packed table contents");
   end
   if (TBL_AW != 8 || TBL_DW != 2 * NIB_W) begin : g_bad_tbl
      $error("sbx_shared_unit: table must be 256 x two nibbles");
   end

   sbx_mode_e             mode;
   logic                  go;
   logic                  seq_rd;
   logic                  rd_en;
   logic                  lo_sel;
   logic [BOX_W-1:0]      box;
   logic [IN_W-1:0]       word;
   logic [TBL_AW-1:0]     des_addr;
   logic [TBL_AW-1:0]     tbl_addr;
   logic [TBL_DW-1:0]     tbl_q;

   assign mode     = sbx_mode_e'(mode_i);
   assign go       = start_i && (mode == MODE_DES);
   assign rd_en    = seq_rd || (!busy_o && mode == MODE_AES);
   assign tbl_addr = busy_o ? des_addr : aes_byte_i;

   sbx_seq #(
      .NBOX  (NBOX),
      .GRP_W (GRP_W),
      .NIB_W (NIB_W),
      .DW    (TBL_DW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go),
      .word_i   (des_in_i),
      .rom_q_i  (tbl_q),
      .lo_sel_i (lo_sel),
      .busy_o   (busy_o),
      .rd_en_o  (seq_rd),
      .box_o    (box),
      .word_o   (word),
      .done_o   (done_o),
      .result_o (des_out_o)
   );

   sbx_addr #(
      .NBOX  (NBOX),
      .GRP_W (GRP_W),
      .AW    (TBL_AW)
   ) u_addr (
      .word_i   (word),
      .box_i    (box),
      .addr_o   (des_addr),
      .lo_sel_o (lo_sel)
   );

   sbx_rom #(
      .AW (TBL_AW),
      .DW (TBL_DW)
   ) u_rom (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (rd_en),
      .addr  (tbl_addr),
      .q     (tbl_q)
   );

   assign sub_byte_o = tbl_q;

endmodule

// File: rtl/sbx_shared_unit_chk.sv
module sbx_shared_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mode_i,
   input logic        start_i,
   input logic [7:0]  aes_byte_i,
   input logic        busy_o,
   input logic        done_o,
   input logic [31:0] des_out_o,
   input logic [7:0]  sub_byte_o
);

   localparam logic [3:0] DONE_AT = 4'(sbx_pkg::NBOX + 1);

   logic [3:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
      end else if (start_i && !mode_i && !busy_o) begin
         since_q <= '0;
      end else if (busy_o) begin
         since_q <= since_q + 4'd1;
      end
   end

   AST_AES_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && mode_i) |=> (sub_byte_o == sbx_pkg::packed_byte($past(aes_byte_i)))); // R3
   AST_IDLE_DES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !mode_i) |=> $stable(sub_byte_o)); // R4
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !mode_i && !busy_o) |=> busy_o); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (since_q == DONE_AT)); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R7
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && since_q != DONE_AT - 4'd1) |=> busy_o); // R8
   AST_MODE_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && mode_i && !busy_o) |=> !busy_o); // R9
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !done_o) |-> $stable(des_out_o)); // R10

endmodule

bind sbx_shared_unit sbx_shared_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .start_i    (start_i),
   .aes_byte_i (aes_byte_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .des_out_o  (des_out_o),
   .sub_byte_o (sub_byte_o)
);

// File: tb/sbx_shared_unit_tb_top.sv
`timescale 1ns/1ps
module sbx_shared_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_i = 1'b0;
   logic        start_i = 1'b0;
   logic [47:0] des_in_i = '0;
   logic [7:0]  aes_byte_i = '0;
   logic        busy_o;
   logic        done_o;
   logic [31:0] des_out_o;
   logic [7:0]  sub_byte_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sbx_shared_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_i     (mode_i),
      .start_i    (start_i),
      .des_in_i   (des_in_i),
      .aes_byte_i (aes_byte_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .des_out_o  (des_out_o),
      .sub_byte_o (sub_byte_o)
   );

   // Reference boxes, 64 nibbles each, entry 0 first.
   localparam logic [255:0] REF_BOX [8] = '{
      256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
      256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
      256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
      256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
      256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
      256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
      256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
      256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
   };

   function automatic logic [3:0] ref_nib(input int box, input int idx);
      return REF_BOX[box][255 - 4*idx -: 4];
   endfunction

   function automatic logic [7:0] ref_byte(input int a);
      return {ref_nib(a / 32, 2 * (a % 32)), ref_nib(a / 32, 2 * (a % 32) + 1)};
   endfunction

   // Entry index -> 6-bit group (inverse of row/column split).
   function automatic logic [5:0] grp_of(input logic [5:0] idx);
      return {idx[5], idx[3:0], idx[4]};
   endfunction

   function automatic logic [3:0] exp_nib(input logic [47:0] w, input int k);
      logic [5:0] g;
      g = w[47 - 6*k -: 6];
      return ref_nib(k, int'({g[5], g[0], g[4:1]}));
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Runs one substitution; optionally pokes start with another word mid-way.
   task automatic des_op(input logic [47:0] w, input bit poke, input logic [47:0] w_alt);
      @(negedge clk);
      mode_i = 1'b0;
      start_i = 1'b1;
      des_in_i = w;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chk("R5 busy after start", 64'(busy_o), 64'd1);
      for (int k = 1; k <= 9; k++) begin
         if (poke) begin
            start_i = (k == 3 || k == 9);
            if (k == 3) des_in_i = w_alt;
         end
         @(posedge clk);
         @(negedge clk);
         start_i = 1'b0;
         if (k < 9) chk(poke ? "R8 done low while busy" : "R7 done low while busy", 64'(done_o), 64'd0);
      end
      chk("R7 done at ninth edge", 64'(done_o), 64'd1);
      chk("R7 busy low with done", 64'(busy_o), 64'd0);
      for (int k = 0; k < 8; k++) begin
         chk(poke ? "R8 result from first word" : "R6 box nibble",
             64'(des_out_o[31 - 4*k -: 4]), 64'(exp_nib(w, k)));
      end
      @(posedge clk);
      @(negedge clk);
      chk("R7 done single cycle", 64'(done_o), 64'd0);
      chk(poke ? "R8 no restart" : "R7 idle after done", 64'(busy_o), 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      logic [47:0] w;
      logic [47:0] lfsr;
      logic [31:0] held;
      logic [7:0]  held_b;

      repeat (3) @(negedge clk);
      chk("R1 busy in reset", 64'(busy_o), 64'd0);
      chk("R1 done in reset", 64'(done_o), 64'd0);
      chk("R1 result in reset", 64'(des_out_o), 64'd0);
      chk("R1 byte in reset", 64'(sub_byte_o), 64'd0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 busy after reset", 64'(busy_o), 64'd0);
      chk("R1 result after reset", 64'(des_out_o), 64'd0);

      // R3 / R2: every table byte through the byte-lookup path.
      mode_i = 1'b1;
      for (int a = 0; a < 256; a++) begin
         aes_byte_i = 8'(a);
         @(posedge clk);
         @(negedge clk);
         chk("R3 R2 table byte", 64'(sub_byte_o), 64'(ref_byte(a)));
         if (a == 0) chk("R2 first byte", 64'(sub_byte_o), 64'hE4);
      end

      // R4: Feistel mode idle, address changes must not reach the output.
      mode_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      held_b = sub_byte_o;
      for (int i = 0; i < 6; i++) begin
         aes_byte_i = 8'(17 * i + 3);
         @(posedge clk);
         @(negedge clk);
         chk("R4 byte held in Feistel idle", 64'(sub_byte_o), 64'(held_b));
      end

      // R6: 64 operations cover all 512 entries, each box at a distinct index.
      for (int j = 0; j < 64; j++) begin
         for (int k = 0; k < 8; k++) begin
            w[47 - 6*k -: 6] = grp_of(6'((j + 7*k) % 64));
         end
         des_op(w, 1'b0, '0);
      end

      // Pseudo-random full words.
      lfsr = 48'hA5C3_1E77_0B92;
      for (int n = 0; n < 24; n++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 7);
         lfsr = lfsr ^ (lfsr << 17);
         des_op(lfsr, 1'b0, '0);
      end

      // R8: starts during busy are ignored.
      des_op(48'hFFFF_FFFF_FFFF, 1'b1, 48'h0000_0000_0000);
      des_op(48'h1234_5678_9ABC, 1'b1, 48'hFEDC_BA98_7654);

      // R10: result holds while idle, even with input and mode activity.
      held = des_out_o;
      for (int i = 0; i < 8; i++) begin
         des_in_i = 48'(i * 48'h0101_0101_0101);
         mode_i = i[0];
         aes_byte_i = 8'(i);
         @(posedge clk);
         @(negedge clk);
         chk("R10 result held while idle", 64'(des_out_o), 64'(held));
      end

      // R9: start in byte-lookup mode is ignored.
      mode_i = 1'b1;
      start_i = 1'b1;
      des_in_i = 48'h0;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 11; i++) begin
         chk("R9 busy stays low", 64'(busy_o), 64'd0);
         chk("R9 done stays low", 64'(done_o), 64'd0);
         @(posedge clk);
         @(negedge clk);
      end
      chk("R9 result unchanged", 64'(des_out_o), 64'(held));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule